// File: doc/BRIEF.md
# Phase-Difference Frequency Discriminator

This block estimates instantaneous frequency from a stream of phase samples. Each phase sample is an unsigned fraction of a full turn. Before differencing, the sample may be multiplied by 1, 2, 4 or 8, modulo a full turn, which removes M-ary phase modulation. The block subtracts from the scaled sample the scaled sample taken a programmable number of accepted samples earlier. The result is a signed frequency word. The subtraction wraps in two's complement, so the output is the shortest signed phase step over that span.

The block sits after a rectangular-to-polar stage and ahead of any post-filtering. Three settings control it: a multiplier code, a delay code and an enable. These settings are taken in only on cycles with no input sample, so every output is computed with one consistent set of settings. After reset, after a change of delay, or after the block has been disabled, the delay line must refill before any output is flagged valid.

Top module: `freq_disc`

## Requirements
- R1: The multiplier code `mult_sel_i` (value k, 0..3) shifts the 16-bit phase left by k bits. The top k bits are discarded and the low k bits are filled with zeros, which gives a multiply by 2^k modulo a full turn.
- R2: The delay code `dly_sel_i` (value d, 0..7) makes the output the current scaled phase minus the scaled phase from d+1 accepted samples earlier, i.e. H(z)=1-z^-(d+1).
- R3: The difference is a 16-bit two's complement value that wraps. For example, 0x0010 minus 0xFFF0 gives +0x0020.
- R4: With active delay code d, `freq_vld_o` stays low for the first d+1 accepted samples after the delay line was emptied, and is high for every accepted sample after that.
- R5: When the active enable is low, input samples are ignored: no output is flagged valid and the delay line does not advance.
- R6: `mult_sel_i`, `dly_sel_i` and `en_i` take effect only at a clock edge where `phase_vld_i` is low. Changes made while samples are streaming have no effect on those samples.
- R7: The result for a sample appears one clock after the edge that accepts it, with `freq_vld_o` high for exactly that one cycle. When no sample is accepted, `freq_vld_o` is low.
- R8: The delay line is emptied when, at an idle edge, the delay code presented differs from the active one, or the enable presented is low.
- R9: While `rst_ni` is low, `freq_vld_o` and `freq_o` are 0, and the active settings are disabled, multiplier 1 and delay 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_i | input | 16 | Phase sample, unsigned fraction of a turn |
| phase_vld_i | input | 1 | Phase sample strobe |
| mult_sel_i | input | 2 | Phase multiplier code k (x2^k) |
| dly_sel_i | input | 3 | Delay code d (d+1 samples) |
| en_i | input | 1 | Discriminator enable |
| freq_o | output | 16 | Signed frequency word |
| freq_vld_o | output | 1 | Frequency word strobe |

## Verification
A result is due exactly one clock after the edge that accepts a sample. New settings are due at the first edge with no sample, and they apply from the sample after that edge. The bench drives inputs on the falling edge and checks on the falling edge that follows, so each check lands one rising edge after its stimulus. It keeps a model of the active settings, the stored history and the fill count, and updates that model only at the same idle edges the design uses. It checks `freq_vld_o` on every cycle, including idle cycles and cycles that receive a sample while disabled.

// File: rtl/freq_disc_pkg.sv
package freq_disc_pkg;
  localparam int unsigned PH_W    = 16;
  localparam int unsigned MAX_DLY = 8;
  localparam int unsigned MAX_SH  = 3;
  localparam int unsigned DLY_W   = $clog2(MAX_DLY);
  localparam int unsigned SH_W    = $clog2(MAX_SH + 1);

  typedef logic [PH_W-1:0]  phase_t;
  typedef logic [DLY_W-1:0] dly_sel_t;
  typedef logic [SH_W-1:0]  sh_sel_t;

  typedef struct packed {
    logic     en;
    sh_sel_t  mult;
    dly_sel_t dly;
  } disc_cfg_t;
endpackage

// File: rtl/fd_cfg.sv
module fd_cfg
  import freq_disc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      idle_i,
  input  disc_cfg_t cfg_i,
  output disc_cfg_t act_o,
  output logic      flush_o
);
  // empty the history when the span changes or the block is switched off
  assign flush_o = idle_i && (cfg_i.dly != act_o.dly || !cfg_i.en);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_o <= '0;
    else if (idle_i) act_o <= cfg_i;
  end

  // R6
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |=> $stable(act_o));
endmodule

// File: rtl/fd_shift.sv
module fd_shift
  import freq_disc_pkg::*;
(
  input  phase_t  ph_i,
  input  sh_sel_t sel_i,
  output phase_t  ph_o
);
  phase_t opts [MAX_SH+1];

  for (genvar k = 0; k <= MAX_SH; k++) begin : g_opt
    if (k == 0) begin : g_id
      assign opts[k] = ph_i;
    end else begin : g_sh
      assign opts[k] = {ph_i[PH_W-1-k:0], {k{1'b0}}};
    end
  end

  assign ph_o = opts[sel_i];
endmodule

// File: rtl/fd_dline.sv
module fd_dline
  import freq_disc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     push_i,
  input  logic     flush_i,
  input  phase_t   ph_i,
  input  dly_sel_t sel_i,
  output phase_t   old_o,
  output logic     full_o
);
  localparam int unsigned CNT_W = $clog2(MAX_DLY + 1);

  phase_t           taps [MAX_DLY];
  logic [CNT_W-1:0] fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) taps[0] <= '0;
    else if (push_i) taps[0] <= ph_i;
  end

  for (genvar i = 1; i < MAX_DLY; i++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) taps[i] <= '0;
      else if (push_i) taps[i] <= taps[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fill_q <= '0;
    else if (flush_i) fill_q <= '0;
    else if (push_i && fill_q != CNT_W'(MAX_DLY)) fill_q <= fill_q + 1'b1;
  end

  assign old_o  = taps[sel_i];
  assign full_o = fill_q > {1'b0, sel_i};

  // R4
  fill_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= CNT_W'(MAX_DLY));
  // R8
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> fill_q == '0);
  // R5
  no_push_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !flush_i) |=> $stable(fill_q));
endmodule

// File: rtl/freq_disc.sv
module freq_disc
  import freq_disc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] phase_i,
  input  logic        phase_vld_i,
  input  logic [1:0]  mult_sel_i,
  input  logic [2:0]  dly_sel_i,
  input  logic        en_i,
  output logic [15:0] freq_o,
  output logic        freq_vld_o
);
  disc_cfg_t cfg_in, act;
  logic      flush, push, full;
  phase_t    ph_sh, ph_old;

  assign cfg_in = '{en: en_i, mult: mult_sel_i, dly: dly_sel_i};

  fd_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idle_i  (!phase_vld_i),
    .cfg_i   (cfg_in),
    .act_o   (act),
    .flush_o (flush)
  );

  assign push = phase_vld_i && act.en;

  fd_shift u_shift (
    .ph_i  (phase_i),
    .sel_i (act.mult),
    .ph_o  (ph_sh)
  );

  fd_dline u_dline (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .flush_i (flush),
    .ph_i    (ph_sh),
    .sel_i   (act.dly),
    .old_o   (ph_old),
    .full_o  (full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freq_o     <= '0;
      freq_vld_o <= 1'b0;
    end else begin
      freq_vld_o <= push && full;
      if (push) freq_o <= ph_sh - ph_old;  // wraps mod a turn
    end
  end

  // R7
  vld_needs_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freq_vld_o |-> $past(phase_vld_i));
  // R5
  off_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act.en |=> !freq_vld_o);
  // R7
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_vld_i |=> $stable(freq_o));
endmodule

// File: tb/sim_freq_disc.sv
module sim_freq_disc;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [15:0] phase_i;
  logic        phase_vld_i;
  logic [1:0]  mult_sel_i;
  logic [2:0]  dly_sel_i;
  logic        en_i;
  logic [15:0] freq_o;
  logic        freq_vld_o;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  freq_disc u0 (.*);

  // model of active settings and history
  logic        m_en;
  logic [1:0]  m_mult;
  logic [2:0]  m_dly;
  int          m_cnt;
  logic [15:0] hist [8];
  logic [15:0] seed = 16'h1234;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s got %h exp %h", tag, act, exp);
    end
  endtask

  task automatic idle(string tag);
    phase_vld_i = 1'b0;
    if (dly_sel_i != m_dly || !en_i) m_cnt = 0;
    m_en = en_i; m_mult = mult_sel_i; m_dly = dly_sel_i;
    @(negedge clk_i);
    chk({tag, " R7 idle vld"}, {15'd0, freq_vld_o}, 16'd0);
  endtask

  task automatic put(logic [15:0] ph, string tag);
    logic [15:0] sh, ed;
    logic ev;
    phase_i = ph; phase_vld_i = 1'b1;
    sh = 16'(ph << m_mult);
    ev = 1'b0; ed = 16'd0;
    if (m_en) begin
      ev = m_cnt > int'(m_dly);
      ed = sh - hist[m_dly];
      for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = sh;
      if (m_cnt < 8) m_cnt++;
    end
    @(negedge clk_i);
    chk({tag, " R4 R5 vld"}, {15'd0, freq_vld_o}, {15'd0, ev});
    if (ev) chk({tag, " R1 R2 R3 data"}, freq_o, ed);
  endtask

  function automatic logic [15:0] nxt();
    seed = seed * 16'd25173 + 16'd13849;
    return seed;
  endfunction

  initial begin
    for (int i = 0; i < 8; i++) hist[i] = '0;
    m_en = 0; m_mult = 0; m_dly = 0; m_cnt = 0;
    rst_ni = 1'b0; phase_i = '0; phase_vld_i = 1'b0;
    mult_sel_i = '0; dly_sel_i = '0; en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R9 reset vld", {15'd0, freq_vld_o}, 16'd0);
    chk("R9 reset data", freq_o, 16'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // disabled: samples ignored
    put(16'h4000, "R5 off");
    put(16'h8000, "R5 off");
    idle("R5");

    // sweep every multiplier and delay
    en_i = 1'b1;
    for (int mm = 0; mm < 4; mm++) begin
      for (int dd = 0; dd < 8; dd++) begin
        mult_sel_i = 2'(mm); dly_sel_i = 3'(dd);
        idle("R6 load");
        for (int s = 0; s < 14; s++) begin
          put(nxt(), "sweep");
          if (s % 5 == 4) idle("R2 gap");
        end
      end
    end

    // wrap across zero
    mult_sel_i = 2'd0; dly_sel_i = 3'd0;
    idle("R8 load");
    put(16'hFFF0, "R3 wrap");
    put(16'h0010, "R3 wrap");
    put(16'hFFF0, "R3 wrap");

    // changes while streaming are not applied
    mult_sel_i = 2'd3; dly_sel_i = 3'd5;
    for (int s = 0; s < 6; s++) put(nxt(), "R6 hold");
    idle("R8 flush");
    for (int s = 0; s < 9; s++) put(nxt(), "R8 refill");

    // disable then re-enable empties history
    en_i = 1'b0;
    idle("R5 off");
    put(16'h1111, "R5 off");
    en_i = 1'b1;
    idle("R5 on");
    for (int s = 0; s < 8; s++) put(nxt(), "R4 refill");
    idle("end");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R7 got hang exp done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule